// File: doc/BRIEF.md
# Packed-Decimal Adder-Subtractor

This combinational unit adds or subtracts two unsigned packed-decimal numbers, each made of `NDIG` four-bit decimal digits with the least significant digit in bits [3:0]. Each digit position has a four-bit binary adder. A correction stage follows it and turns the binary digit sum back into a decimal digit. A carry moves from each digit to the next more significant one.

To subtract, each digit of the subtrahend is replaced by its nine's complement, and then the two numbers are added. If the most significant digit produces a carry, that carry goes back in at the least significant digit, and the result is positive. If there is no carry, the raw sum holds the negative result in nine's-complement form. The unit converts it to its magnitude and raises a sign flag. Two equal operands give a plain zero, never a negative zero.

Top module: `bcd_addsub`

## Requirements
- R1: In add mode (`sub_mode`=0) the `res` output equals (A+B) mod 10^NDIG as packed decimal, with the low-order digit at bits [3:0].
- R2: In add mode `carry_out` is 1 exactly when A+B ≥ 10^NDIG.
- R3: A digit whose binary sum exceeds 9 passes a carry to the next digit. A chain of such carries ripples across every digit (for example 0999+0001 gives 1000).
- R4: In subtract mode with A > B, `res` equals A−B and `negative` is 0. The carry out of the top digit goes back in as an end-around carry.
- R5: In subtract mode with A < B, `res` equals B−A and `negative` is 1. A negative result is never zero.
- R6: In subtract mode with A = B, `res` is all zero digits and `negative` is 0.
- R7: In subtract mode `carry_out` is always 0.
- R8: In add mode `negative` is always 0.
- R9: For valid decimal inputs, every four-bit digit of `res` is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4*NDIG | Minuend or first addend, packed decimal |
| b | input | 4*NDIG | Subtrahend or second addend, packed decimal |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| res | output | 4*NDIG | Sum, or magnitude of the difference, packed decimal |
| carry_out | output | 1 | Decimal overflow of an addition; 0 when subtracting |
| negative | output | 1 | Set when the difference is below zero |

## Verification
The bench builds the unit with the default of four digits, so operand values run from 0 to 9999. At that width, integer references in the bench can cover the full-range corners: 9999+9999, 0−9999 and 9999−0. They also reach long carry ripples such as 0999+0001 and 9999+0001. Directed cases cover positive, negative and equal differences. A batch of random digit patterns is then checked against decoded decimal arithmetic.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic logic digit_ok(input digit_t d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
(
  input  digit_t din,
  output digit_t dout
);
  // invert, add ten, drop the carry: gives 9 - din
  assign dout = ~din + 4'd10;

  always_comb begin
    if (digit_ok(din)) begin
      // R9
      nines_range_chk: assert (digit_ok(dout) && (din + dout == 4'd9));
    end
  end
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  digit_t x,
  input  digit_t y,
  input  logic   cin,
  output digit_t sum,
  output logic   cout
);
  logic [DIGIT_W:0] raw;
  logic             fix;

  always_comb begin
    raw  = {1'b0, x} + {1'b0, y} + {{DIGIT_W{1'b0}}, cin};
    fix  = raw > 5'd9;
    sum  = raw[DIGIT_W-1:0] + (fix ? 4'd6 : 4'd0);
    cout = fix;
  end

  always_comb begin
    if (digit_ok(x) && digit_ok(y)) begin
      // R3
      digit_carry_chk: assert (cout == ((x + y + cin) >= 10));
      // R9
      digit_valid_chk: assert (digit_ok(sum));
    end
  end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int W = NDIG*DIGIT_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [NDIG:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_digit_add u_dig (
      .x   (x[i*DIGIT_W +: DIGIT_W]),
      .y   (y[i*DIGIT_W +: DIGIT_W]),
      .cin (carry[i]),
      .sum (sum[i*DIGIT_W +: DIGIT_W]),
      .cout(carry[i+1])
    );
  end

  assign cout = carry[NDIG];
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int W = NDIG*DIGIT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub_mode,
  output logic [W-1:0] res,
  output logic         carry_out,
  output logic         negative
);
  logic [W-1:0] b_comp, b_eff;
  logic [W-1:0] sum_plain, sum_eac, sum_mag;
  logic         c_plain, c_eac;
  logic         mag_zero;

  for (genvar i = 0; i < NDIG; i++) begin : g_comp
    bcd_nines u_cb (
      .din (b[i*DIGIT_W +: DIGIT_W]),
      .dout(b_comp[i*DIGIT_W +: DIGIT_W])
    );
    bcd_nines u_cs (
      .din (sum_plain[i*DIGIT_W +: DIGIT_W]),
      .dout(sum_mag[i*DIGIT_W +: DIGIT_W])
    );
  end

  assign b_eff = sub_mode ? b_comp : b;

  // raw sum without carry-in
  bcd_chain #(.NDIG(NDIG)) u_plain (
    .x(a), .y(b_eff), .cin(1'b0), .sum(sum_plain), .cout(c_plain)
  );

  // same sum with the end-around carry already applied
  bcd_chain #(.NDIG(NDIG)) u_eac (
    .x(a), .y(b_eff), .cin(1'b1), .sum(sum_eac), .cout(c_eac)
  );

  always_comb begin
    mag_zero = (sum_mag == '0);
    if (!sub_mode) begin
      res       = sum_plain;
      carry_out = c_plain;
      negative  = 1'b0;
    end else if (c_plain) begin
      res       = sum_eac;
      carry_out = 1'b0;
      negative  = 1'b0;
    end else begin
      res       = sum_mag;
      carry_out = 1'b0;
      negative  = !mag_zero;
    end
  end

  always_comb begin
    // R7
    sub_no_carry_chk: assert (!(sub_mode && carry_out));
    // R8
    add_positive_chk: assert (sub_mode || !negative);
    // R5
    neg_nonzero_chk: assert (!negative || (res != '0));
    if (sub_mode && (a == b)) begin
      // R6
      equal_zero_chk: assert ((res == '0) && !negative);
    end
    if (sub_mode && c_plain) begin
      // R4
      eac_carry_chk: assert (c_eac);
    end
  end
endmodule

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
  localparam int NDIG = 4;
  localparam int W = NDIG*4;
  localparam int MODV = 10000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic sub_mode, carry_out, negative;
  int checks = 0;
  int errors = 0;

  bcd_addsub #(.NDIG(NDIG)) u_bcd_addsub (
    .a(a), .b(b), .sub_mode(sub_mode),
    .res(res), .carry_out(carry_out), .negative(negative)
  );

  function automatic logic [W-1:0] enc(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int i = 0; i < NDIG; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int dec(input logic [W-1:0] p);
    int v = 0;
    for (int i = NDIG-1; i >= 0; i--) v = v*10 + int'(p[i*4 +: 4]);
    return v;
  endfunction

  function automatic logic all_ok(input logic [W-1:0] p);
    for (int i = 0; i < NDIG; i++) if (p[i*4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input int av, input int bv, input logic m);
    @(posedge clk);
    a = enc(av); b = enc(bv); sub_mode = m;
    @(negedge clk);
  endtask

  task automatic do_add(input int av, input int bv, input string req);
    int s;
    apply(av, bv, 1'b0);
    s = av + bv;
    chk({req, " sum"}, dec(res), s % MODV);
    chk("R2 carry", int'(carry_out), int'(s >= MODV));
    chk("R8 sign", int'(negative), 0);
    chk("R9 digits", int'(all_ok(res)), 1);
  endtask

  task automatic do_sub(input int av, input int bv);
    int d;
    apply(av, bv, 1'b1);
    d = av - bv;
    if (d > 0) begin
      chk("R4 diff", dec(res), d);
      chk("R4 sign", int'(negative), 0);
    end else if (d < 0) begin
      chk("R5 diff", dec(res), -d);
      chk("R5 sign", int'(negative), 1);
    end else begin
      chk("R6 zero", dec(res), 0);
      chk("R6 sign", int'(negative), 0);
    end
    chk("R7 carry", int'(carry_out), 0);
    chk("R9 digits", int'(all_ok(res)), 1);
  endtask

  task automatic t_reset_state;
    apply(0, 0, 1'b0);
    chk("R1 idle", dec(res), 0);
    chk("R2 idle", int'(carry_out), 0);
  endtask

  task automatic t_add_dir;
    do_add(1234, 4321, "R1");
    do_add(5, 7, "R1");
    do_add(999, 1, "R3");
    do_add(9999, 1, "R3");
    do_add(9999, 9999, "R2");
    do_add(5000, 5000, "R2");
  endtask

  task automatic t_sub_dir;
    do_sub(4321, 1234);
    do_sub(1000, 1);
    do_sub(9999, 0);
    do_sub(1234, 4321);
    do_sub(0, 9999);
    do_sub(1, 1000);
    do_sub(0, 0);
    do_sub(9999, 9999);
    do_sub(4567, 4567);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      int av = int'($urandom % MODV);
      int bv = int'($urandom % MODV);
      if (k % 2 == 0) do_add(av, bv, "R1");
      else do_sub(av, bv);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; sub_mode = 1'b0;
    t_reset_state();
    t_add_dir();
    t_sub_dir();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule